// File: doc/BRIEF.md
# A/D Sample Buffer with Active-Low Status Flags

This block buffers converted samples between an analog-to-digital converter and a host bus. Every conversion-done pulse offers one 16-bit word to a 1024-entry first-in first-out store. The host takes words out one at a time by pulsing a pop request, and the word appears on the read-data port on the following cycle. A status byte gives the fill state (empty, half full, full) as active-low flags. The same byte also shows the converter busy line and the selected input range code.

A three-bit control register sets the behaviour. One bit disables the store. While that bit is set, both pointers are held at zero and conversions are thrown away, so the host empties the buffer by writing enable, disable, enable. A second bit chooses what raises the data interrupt: every conversion, or the moment the fill level reaches half depth. A third bit chooses whether the event interrupt follows a pacer tick or a rising edge of an external trigger. Both interrupt requests stay asserted until the host pulses the clear input. A push into a full store is dropped and sets a sticky overflow flag. Only disabling the store clears that flag.

Top module: `sample_fifo_flags`

## Requirements
- R1: After reset, read data is 0, both interrupt requests and the overflow flag are 0, the control register is 0, and the status byte shows an empty store.
- R2: Accepted samples come out in the order they were written. A pop taken at a clock edge places the oldest word on read data, and that word is visible after the edge.
- R3: Status bit 4 is 0 when the store holds no words. Bit 5 is 0 when it holds at least 512 words. Bit 6 is 0 when it holds 1024 words. Each of these bits is 1 otherwise.
- R4: Status bit 7 equals the converter busy input, bits 2..0 equal the range code input, and bit 3 reads 0.
- R5: A conversion offered while the store is full is dropped, even if a pop happens in the same cycle. It sets the overflow flag, and the flag stays set while the store remains enabled.
- R6: A pop while the store is empty leaves read data unchanged and moves no pointer, so the next accepted sample is the next word read out.
- R7: While control bit 2 is 1, the store reads as empty, conversions are discarded, pops are ignored and the overflow flag is cleared. After writing the bit back to 0, the store starts empty.
- R8: With control bit 0 at 0, every conversion offered while the store is enabled sets the data interrupt request at that clock edge.
- R9: With control bit 0 at 1, the data interrupt request is set only by an accepted push that takes the fill level from 511 to 512 words without a pop in the same cycle.
- R10: With control bit 1 at 0, a pacer tick sets the event interrupt request. With control bit 1 at 1, only a rising edge of the external trigger sets it.
- R11: A pulse on the interrupt clear input drops both requests. Without that pulse, a request stays asserted. A new set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convDone | input | 1 | One-cycle pulse: a conversion finished |
| convData | input | 16 | Conversion result offered with convDone |
| adcBusy | input | 1 | Converter busy line, shown in status bit 7 |
| rangeSel | input | 3 | Selected input range code, shown in status bits 2..0 |
| popReq | input | 1 | Host read of the data register |
| rdData | output | 16 | Word taken by the most recent accepted pop |
| ctrlWrite | input | 1 | Load strobe for the control register |
| ctrlData | input | 3 | Control value: bit0 data-irq source, bit1 event-irq source, bit2 store disable |
| pacerTick | input | 1 | Pacer timer tick |
| extTrig | input | 1 | External trigger level |
| irqClear | input | 1 | Drops both interrupt requests |
| statusByte | output | 8 | busy, not-full, not-half, not-empty, 0, range code |
| overflow | output | 1 | Sticky flag: a sample was dropped |
| dataIrq | output | 1 | Data interrupt request |
| eventIrq | output | 1 | Event interrupt request |

## Verification
The assertions assume that the synchronous inputs are known at every rising edge after reset. They also assume that a disable write is held for at least one cycle before the enable write. The clearing check needs that cycle to take effect. The stimulus changes every input only at the falling edge, one cycle per operation, and always spaces the enable write from the disable write. Random traffic keeps conversions and pops single-cycle pulses. The half-depth crossing and the full boundary are reached by directed fills rather than by chance.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // control register bit positions
  localparam int CTL_SRC_HALF = 0;
  localparam int CTL_SRC_EXT  = 1;
  localparam int CTL_OFF      = 2;
  localparam int CTL_W        = 3;

  // status byte bit positions
  localparam int ST_EMPTY_N = 4;
  localparam int ST_HALF_N  = 5;
  localparam int ST_FULL_N  = 6;
  localparam int ST_BUSY    = 7;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoStrobe_t;
endpackage

// File: rtl/sfifo_data.sv
module sfifo_data
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             isEmpty,
  output logic             isHalf,
  output logic             isFull,
  output logic             halfCross
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             pushOk, popOk;

  assign isEmpty   = (count == '0);
  assign isFull    = (count == CW'(DEPTH));
  assign isHalf    = (count >= CW'(HALF));
  assign pushOk    = strobe.push && !isFull;
  assign popOk     = strobe.pop && !isEmpty;
  assign halfCross = pushOk && !popOk && (count == CW'(HALF - 1));

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk && !strobe.clear) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk) begin
        rdPtr  <= nextPtr(rdPtr);
        rdData <= mem[rdPtr];
      end
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R6
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && isEmpty) |=> $stable(rdData));

  // R7
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> isEmpty);
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic [CTL_W-1:0]  ctrlData,
  input  logic              convDone,
  input  logic              popReq,
  input  logic              isFull,
  output fifoStrobe_t       strobe,
  output logic              fifoOff,
  output logic              srcHalf,
  output logic              srcExt,
  output logic              overflow
);
  logic [CTL_W-1:0] ctrlReg;

  assign fifoOff = ctrlReg[CTL_OFF];
  assign srcHalf = ctrlReg[CTL_SRC_HALF];
  assign srcExt  = ctrlReg[CTL_SRC_EXT];

  always_comb begin
    strobe.push  = convDone && !fifoOff;
    strobe.pop   = popReq && !fifoOff;
    strobe.clear = fifoOff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWrite) ctrlReg <= ctrlData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overflow <= 1'b0;
    else if (fifoOff) overflow <= 1'b0;
    else if (convDone && isFull) overflow <= 1'b1;
  end

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !fifoOff) |=> overflow);

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !fifoOff && isFull) |=> overflow);
endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq (
  input  logic clk,
  input  logic rstN,
  input  logic convSeen,
  input  logic halfCross,
  input  logic srcHalf,
  input  logic srcExt,
  input  logic pacerTick,
  input  logic extTrig,
  input  logic irqClear,
  output logic dataIrq,
  output logic eventIrq
);
  logic extPrev;
  logic dataSet, eventSet;

  assign dataSet  = srcHalf ? halfCross : convSeen;
  assign eventSet = srcExt ? (extTrig && !extPrev) : pacerTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev  <= 1'b0;
      dataIrq  <= 1'b0;
      eventIrq <= 1'b0;
    end else begin
      extPrev <= extTrig;
      if (dataSet) dataIrq <= 1'b1;
      else if (irqClear) dataIrq <= 1'b0;
      if (eventSet) eventIrq <= 1'b1;
      else if (irqClear) eventIrq <= 1'b0;
    end
  end

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataIrq && !irqClear) |=> dataIrq);

  // R11
  event_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventIrq && !irqClear) |=> eventIrq);

  // R8
  eoc_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convSeen && !srcHalf) |=> dataIrq);

  // R10
  pacer_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pacerTick && !srcExt) |=> eventIrq);
endmodule

// File: rtl/sample_fifo_flags.sv
module sample_fifo_flags
  import sfifo_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int WIDTH   = 16,
  parameter int RANGE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               convDone,
  input  logic [WIDTH-1:0]   convData,
  input  logic               adcBusy,
  input  logic [RANGE_W-1:0] rangeSel,
  input  logic               popReq,
  output logic [WIDTH-1:0]   rdData,
  input  logic               ctrlWrite,
  input  logic [CTL_W-1:0]   ctrlData,
  input  logic               pacerTick,
  input  logic               extTrig,
  input  logic               irqClear,
  output logic [7:0]         statusByte,
  output logic               overflow,
  output logic               dataIrq,
  output logic               eventIrq
);
  fifoStrobe_t strobe;
  logic fifoOff, srcHalf, srcExt;
  logic isEmpty, isHalf, isFull, halfCross;

  sfifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .ctrlData(ctrlData),
    .convDone(convDone), .popReq(popReq), .isFull(isFull),
    .strobe(strobe), .fifoOff(fifoOff), .srcHalf(srcHalf),
    .srcExt(srcExt), .overflow(overflow)
  );

  sfifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(convData),
    .rdData(rdData), .isEmpty(isEmpty), .isHalf(isHalf),
    .isFull(isFull), .halfCross(halfCross)
  );

  sfifo_irq u_irq (
    .clk(clk), .rstN(rstN), .convSeen(strobe.push), .halfCross(halfCross),
    .srcHalf(srcHalf), .srcExt(srcExt), .pacerTick(pacerTick),
    .extTrig(extTrig), .irqClear(irqClear),
    .dataIrq(dataIrq), .eventIrq(eventIrq)
  );

  always_comb begin
    statusByte             = '0;
    statusByte[RANGE_W-1:0] = rangeSel;
    statusByte[ST_EMPTY_N] = !isEmpty;
    statusByte[ST_HALF_N]  = !isHalf;
    statusByte[ST_FULL_N]  = !isFull;
    statusByte[ST_BUSY]    = adcBusy;
  end
endmodule

// File: tb/sample_fifo_flags_bench.sv
module sample_fifo_flags_bench;
  localparam int DEPTH = 1024;
  localparam int HALF  = DEPTH / 2;

  logic clk = 0, rstN = 0;
  logic convDone = 0, adcBusy = 0, popReq = 0, ctrlWrite = 0;
  logic pacerTick = 0, extTrig = 0, irqClear = 0;
  logic [15:0] convData = 0;
  logic [2:0] rangeSel = 0, ctrlData = 0;
  logic [15:0] rdData;
  logic [7:0] statusByte;
  logic overflow, dataIrq, eventIrq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] mq[$];
  logic [15:0] mPop = 0;
  logic [2:0]  mCtrl = 0;
  bit mOvf = 0, mIrqA = 0, mIrqB = 0, mExtPrev = 0;

  always #10 clk = ~clk;

  sample_fifo_flags u_sample_fifo_flags (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convData(convData),
    .adcBusy(adcBusy), .rangeSel(rangeSel), .popReq(popReq), .rdData(rdData),
    .ctrlWrite(ctrlWrite), .ctrlData(ctrlData), .pacerTick(pacerTick),
    .extTrig(extTrig), .irqClear(irqClear), .statusByte(statusByte),
    .overflow(overflow), .dataIrq(dataIrq), .eventIrq(eventIrq)
  );

  function automatic logic [7:0] expStatus(int n, logic busy, logic [2:0] rng);
    return {busy, !(n == DEPTH), !(n >= HALF), !(n == 0), 1'b0, rng};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(bit conv, bit [15:0] d, bit pop, bit clr, bit wr, bit [2:0] wv);
    int sizeB;
    bit pushAcc, popAcc, setA, setB;
    convDone = conv; convData = d; popReq = pop; irqClear = clr;
    ctrlWrite = wr; ctrlData = wv;
    sizeB = mq.size();
    @(posedge clk);
    @(negedge clk);
    convDone = 0; popReq = 0; irqClear = 0; ctrlWrite = 0;
    pushAcc = 0; popAcc = 0;
    if (mCtrl[2]) begin
      mq.delete();
      mOvf = 0;
    end else begin
      if (pop && sizeB > 0) begin mPop = mq.pop_front(); popAcc = 1; end
      if (conv) begin
        if (sizeB >= DEPTH) mOvf = 1;
        else begin mq.push_back(d); pushAcc = 1; end
      end
    end
    setA = !mCtrl[2] && ((!mCtrl[0] && conv) ||
           (mCtrl[0] && pushAcc && !popAcc && sizeB == HALF - 1));
    setB = (!mCtrl[1] && pacerTick) || (mCtrl[1] && extTrig && !mExtPrev);
    mExtPrev = extTrig;
    pacerTick = 0;
    mIrqA = setA ? 1'b1 : (clr ? 1'b0 : mIrqA);
    mIrqB = setB ? 1'b1 : (clr ? 1'b0 : mIrqB);
    if (wr) mCtrl = wv;
    check("R2 read data", 32'(rdData), 32'(mPop));
    check("R3 status", 32'(statusByte), 32'(expStatus(mq.size(), adcBusy, rangeSel)));
    check("R5 overflow", 32'(overflow), 32'(mOvf));
    check(mCtrl[0] ? "R9 data irq" : "R8 data irq", 32'(dataIrq), 32'(mIrqA));
    check("R10 event irq", 32'(eventIrq), 32'(mIrqB));
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic setCtrl(bit [2:0] v);
    tick(0, 0, 0, 0, 1, v);
  endtask

  // R7: enable, disable, enable sequence
  task automatic resetStore(bit [1:0] src);
    setCtrl({1'b1, src});
    idle();
    setCtrl({1'b0, src});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] keep;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", 32'(statusByte), 32'h60);
    check("R1 read data", 32'(rdData), 0);
    check("R1 irqs/ovf", 32'({dataIrq, eventIrq, overflow}), 0);

    // R4 busy and range passthrough
    adcBusy = 1; rangeSel = 3'd5;
    #1 check("R4 status", 32'(statusByte), 32'hE5);
    adcBusy = 0; rangeSel = 3'd2;
    #1 check("R4 status", 32'(statusByte), 32'h62);

    // R2 ordering, R8 per-conversion irq
    tick(1, 16'h1111, 0, 0, 0, 0);
    check("R8 irq after conversion", 32'(dataIrq), 1);
    tick(1, 16'h2222, 0, 1, 0, 0);
    check("R11 set wins over clear", 32'(dataIrq), 1);
    tick(1, 16'h3333, 0, 0, 0, 0);
    tick(0, 0, 1, 0, 0, 0);
    check("R2 first word", 32'(rdData), 32'h1111);
    tick(0, 0, 1, 1, 0, 0);
    check("R11 clear drops", 32'(dataIrq), 0);
    idle();
    check("R11 stays low", 32'(dataIrq), 0);
    tick(0, 0, 1, 0, 0, 0);
    check("R2 third word", 32'(rdData), 32'h3333);
    // R6 pop on empty
    tick(0, 0, 1, 0, 0, 0);
    check("R6 data held", 32'(rdData), 32'h3333);
    tick(1, 16'hABCD, 1, 0, 0, 0);
    check("R6 data held with push", 32'(rdData), 32'h3333);
    tick(0, 0, 1, 0, 0, 0);
    check("R6 pointer intact", 32'(rdData), 32'hABCD);
    tick(0, 0, 0, 1, 0, 0);

    // R9 half-full crossing, R5 overflow
    resetStore(2'b01);
    for (int i = 0; i < HALF - 1; i++) tick(1, 16'(i * 7 + 3), 0, 0, 0, 0);
    check("R9 no irq below half", 32'(dataIrq), 0);
    check("R3 half bit high", 32'(statusByte[5]), 1);
    tick(1, 16'hBEEF, 0, 0, 0, 0);
    check("R9 irq at half", 32'(dataIrq), 1);
    check("R3 half bit low", 32'(statusByte[5]), 0);
    tick(0, 0, 0, 1, 0, 0);
    for (int i = HALF; i < DEPTH; i++) tick(1, 16'(i ^ 16'h5A5A), 0, 0, 0, 0);
    check("R3 full bit low", 32'(statusByte[6]), 0);
    check("R9 no irq past half", 32'(dataIrq), 0);
    tick(1, 16'hDEAD, 1, 0, 0, 0);
    check("R5 overflow set", 32'(overflow), 1);
    for (int i = 0; i < DEPTH + 2; i++) tick(0, 0, 1, 0, 0, 0);
    check("R5 overflow sticky", 32'(overflow), 1);
    check("R3 empty bit low", 32'(statusByte[4]), 0);

    // R7 disable discards and clears
    tick(1, 16'h0F0F, 0, 0, 0, 0);
    setCtrl(3'b100);
    tick(1, 16'h7777, 0, 0, 0, 0);
    check("R7 overflow cleared", 32'(overflow), 0);
    check("R7 empty while off", 32'(statusByte[4]), 0);
    check("R7 no irq while off", 32'(dataIrq), 0);
    tick(0, 0, 1, 0, 0, 0);
    setCtrl(3'b000);
    check("R7 empty after toggle", 32'(statusByte[4]), 0);
    keep = rdData;
    tick(1, 16'h4242, 0, 1, 0, 0);
    tick(0, 0, 1, 0, 0, 0);
    check("R7 fresh start", 32'(rdData), 32'h4242);

    // R10 event interrupt sources
    tick(0, 0, 0, 1, 0, 0);
    pacerTick = 1; idle();
    check("R10 pacer sets", 32'(eventIrq), 1);
    tick(0, 0, 0, 1, 0, 0);
    extTrig = 1; idle(); idle();
    check("R10 ext ignored in pacer mode", 32'(eventIrq), 0);
    extTrig = 0; setCtrl(3'b010);
    pacerTick = 1; idle();
    check("R10 pacer ignored in ext mode", 32'(eventIrq), 0);
    extTrig = 1; idle();
    check("R10 ext edge sets", 32'(eventIrq), 1);
    tick(0, 0, 0, 1, 0, 0);
    idle();
    check("R10 level does not retrigger", 32'(eventIrq), 0);
    extTrig = 0; idle();

    // random traffic across both data-irq modes
    for (int i = 0; i < 4000; i++) begin
      bit c, p, k;
      c = ($urandom % 100) < 55;
      p = ($urandom % 100) < 45;
      k = ($urandom % 100) < 10;
      pacerTick = ($urandom % 100) < 5;
      extTrig = ($urandom % 100) < 30;
      adcBusy = $urandom % 2;
      rangeSel = 3'($urandom);
      if (i == 2000) setCtrl(3'b001);
      else if (($urandom % 1000) == 0) resetStore(2'($urandom));
      else tick(c, 16'($urandom), p, k, 0, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule